// File: doc/BRIEF.md
# Request Tracker Occupancy Monitor

This block observes a memory request tracker that holds a fixed number of entries. Each cycle it may see an allocate pulse and a retire pulse. Each allocation carries a two-bit request kind. The block keeps a saturating live occupancy for that tracker. It keeps a second occupancy for a coherency tracker that has its own allocate and retire pulses.

Two 48-bit event counters are each steered by an 18-bit selector. The selector holds an 8-bit event code, an 8-bit unit mask and a 2-bit sub-mode. A counter can do one of the following:
- sum the occupancy on every cycle;
- count the cycles in which the tracker holds any request;
- count the cycles in which the tracker is at least half full;
- count allocations, filtered by kind.

Software writes the selectors and the counters through a small register port. It reads them back through the same port, using a combinational read path.

Register map, indexed by `reg_addr`:

| Address | Contents |
|---|---|
| 0 | selector of counter 0 |
| 1 | selector of counter 1 |
| 2 | counter 0 value |
| 3 | counter 1 value |

Selector layout:

| Bits | Field |
|---|---|
| [7:0] | event code |
| [15:8] | unit mask |
| [17:16] | sub-mode |

Request kind encoding on `alloc_kind`:

| Value | Kind |
|---|---|
| 0 | read |
| 1 | full write |
| 2 | partial write |
| 3 | eviction |

Top module: `trk_occ_mon`

## Requirements
- R1: `trk_occ` rises by one on an allocate-only cycle and falls by one on a retire-only cycle. It stays within 0 to DEPTH, and it is unchanged when allocate and retire come together. The coherency occupancy follows the same rule with its own pulses.
- R2: Code 0x80 with mask 0x01 and sub-mode 0 makes counter 0 add the pre-edge tracker occupancy on every cycle.
- R3: Code 0x80, mask 0x01, sub-mode 1 makes either counter add one on each cycle in which the occupancy is non-zero.
- R4: Code 0x80, mask 0x01, sub-mode 2 makes either counter add one on each cycle in which twice the occupancy is at least DEPTH.
- R5: On counter 1, code 0x80 with mask 0x01 and sub-mode 0 leaves the counter unchanged. Sub-mode 3 under code 0x80 leaves either counter unchanged.
- R6: Code 0x81 with mask 0x01 adds one per allocate pulse, whatever the kind. The sub-mode bits are ignored by allocation codes.
- R7: Code 0x81 with mask 0x20 counts allocations of kinds 1, 2 and 3. Code 0x81 with mask 0x80 counts only kind 3.
- R8: Code 0x83, mask 0x01, sub-mode 0 makes counter 0 add the coherency occupancy each cycle; counter 1 and other sub-modes stay unchanged. Code 0x84 with mask 0x01 counts coherency allocations on either counter.
- R9: Any other code or mask combination leaves the counter unchanged.
- R10: A write to address 2 or 3 loads that counter, and the write takes priority over the cycle's increment. Counters wrap modulo 2^48. Selectors read back zero-extended.
- R11: After reset, both selectors, both counters and both occupancies read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| alloc_vld | input | 1 | main tracker allocate pulse |
| alloc_kind | input | 2 | request kind of the allocation |
| retire_vld | input | 1 | main tracker retire pulse |
| coh_alloc_vld | input | 1 | coherency tracker allocate pulse |
| coh_retire_vld | input | 1 | coherency tracker retire pulse |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register index |
| reg_wdata | input | CNT_W | register write data |
| reg_rdata | output | CNT_W | register read data for `reg_addr` |
| trk_occ | output | clog2(DEPTH+1) | live main tracker occupancy |

## Verification
A pseudo-random traffic pattern drives the tracker in two phases, first fill-biased and then drain-biased. Every selector in a table of legal and illegal combinations is applied to both counters during this traffic.

The checks aim at the following corner cases:
- Saturation at DEPTH and at zero. A design that wraps would jump to 0 or DEPTH.
- The simultaneous allocate-and-retire case. A design that gets it wrong would step by one.
- The counter-0-only weighted modes. A permissive design would count on counter 1.
- The write-filter kinds. A design that leaves evictions out of the write count would undercount.
- Write-over-increment priority. A design that gets it wrong reads one too high.
- The 48-bit wrap. A design with a narrower carry or a clamped counter misreads.

// File: rtl/trk_occ_pkg.sv
package trk_occ_pkg;

   localparam int NUM_CTR = 2;
   localparam int SEL_W   = 18;

   localparam logic [7:0] EV_TRK_OCC   = 8'h80;
   localparam logic [7:0] EV_TRK_ALLOC = 8'h81;
   localparam logic [7:0] EV_COH_OCC   = 8'h83;
   localparam logic [7:0] EV_COH_ALLOC = 8'h84;

   localparam logic [7:0] UM_ALL   = 8'h01;
   localparam logic [7:0] UM_WRITE = 8'h20;
   localparam logic [7:0] UM_EVICT = 8'h80;

   typedef enum logic [1:0] {
      SUB_WEIGHT = 2'd0,
      SUB_ANY    = 2'd1,
      SUB_HALF   = 2'd2,
      SUB_OFF    = 2'd3
   } occ_sub_e;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_FULLW = 2'd1,
      KIND_PARTW = 2'd2,
      KIND_EVICT = 2'd3
   } req_kind_e;

   typedef struct packed {
      logic [1:0] sub;
      logic [7:0] mask;
      logic [7:0] code;
   } evt_sel_t;

endpackage

// File: rtl/trk_occ_track.sv
module trk_occ_track #(
   parameter int DEPTH = 16,
   parameter int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             down,
   output logic [OCC_W-1:0] occ
);

   localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ <= '0;
      end else if (up && !down && occ != FULL) begin
         occ <= occ + 1'b1;
      end else if (down && !up && occ != '0) begin
         occ <= occ - 1'b1;
      end
   end

endmodule

// File: rtl/trk_ctr_slice.sv
module trk_ctr_slice
   import trk_occ_pkg::*;
#(
   parameter int CTR_IDX = 0,
   parameter int DEPTH   = 16,
   parameter int OCC_W   = $clog2(DEPTH + 1),
   parameter int CNT_W   = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  evt_sel_t         sel,
   input  logic [OCC_W-1:0] trk_occ,
   input  logic [OCC_W-1:0] coh_occ,
   input  logic             alloc_vld,
   input  logic [1:0]       alloc_kind,
   input  logic             coh_alloc_vld,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [OCC_W:0] DEPTH_X = (OCC_W + 1)'(DEPTH);

   logic [OCC_W-1:0] w_trk;
   logic [OCC_W-1:0] w_coh;
   logic [OCC_W:0]   occ_x2;
   logic             half_full;
   logic             is_write;
   logic [OCC_W-1:0] inc;

   // Weighted accumulation exists only on the first counter.
   generate
      if (CTR_IDX == 0) begin : g_weighted
         assign w_trk = trk_occ;
         assign w_coh = coh_occ;
      end else begin : g_unweighted
         assign w_trk = '0;
         assign w_coh = '0;
      end
   endgenerate

   assign occ_x2    = {trk_occ, 1'b0};
   assign half_full = (occ_x2 >= DEPTH_X);
   assign is_write  = (alloc_kind != KIND_READ);

   always_comb begin
      inc = '0;
      if (sel.code == EV_TRK_OCC && sel.mask == UM_ALL) begin
         case (occ_sub_e'(sel.sub))
            SUB_WEIGHT: inc = w_trk;
            SUB_ANY:    inc = OCC_W'(trk_occ != '0);
            SUB_HALF:   inc = OCC_W'(half_full);
            default:    inc = '0;
         endcase
      end else if (sel.code == EV_TRK_ALLOC) begin
         case (sel.mask)
            UM_ALL:   inc = OCC_W'(alloc_vld);
            UM_WRITE: inc = OCC_W'(alloc_vld && is_write);
            UM_EVICT: inc = OCC_W'(alloc_vld && alloc_kind == KIND_EVICT);
            default:  inc = '0;
         endcase
      end else if (sel.code == EV_COH_OCC && sel.mask == UM_ALL
                   && occ_sub_e'(sel.sub) == SUB_WEIGHT) begin
         inc = w_coh;
      end else if (sel.code == EV_COH_ALLOC && sel.mask == UM_ALL) begin
         inc = OCC_W'(coh_alloc_vld);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load_en) begin
         cnt <= load_val;
      end else begin
         cnt <= cnt + CNT_W'(inc);
      end
   end

endmodule

// File: rtl/trk_occ_mon.sv
module trk_occ_mon
   import trk_occ_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 48,
   parameter int OCC_W  = $clog2(DEPTH + 1),
   parameter int ADDR_W = $clog2(2 * NUM_CTR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_vld,
   input  logic [1:0]        alloc_kind,
   input  logic              retire_vld,
   input  logic              coh_alloc_vld,
   input  logic              coh_retire_vld,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic [OCC_W-1:0]  trk_occ
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("trk_occ_mon: DEPTH must be at least 2");
      end
      if (CNT_W < SEL_W) begin : g_bad_width
         $error("trk_occ_mon: CNT_W must hold a selector");
      end
      if (OCC_W < $clog2(DEPTH + 1)) begin : g_bad_occ
         $error("trk_occ_mon: OCC_W too narrow for DEPTH");
      end
   endgenerate

   logic [OCC_W-1:0]                coh_occ;
   evt_sel_t [NUM_CTR-1:0]          sel_q;
   logic [NUM_CTR-1:0][CNT_W-1:0]   ctr_val;

   trk_occ_track #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_trk_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .up    (alloc_vld),
      .down  (retire_vld),
      .occ   (trk_occ)
   );

   trk_occ_track #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_coh_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .up    (coh_alloc_vld),
      .down  (coh_retire_vld),
      .occ   (coh_occ)
   );

   generate
      for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
         localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(gi);
         localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(NUM_CTR + gi);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_q[gi] <= '0;
            end else if (reg_we && reg_addr == SEL_ADDR) begin
               sel_q[gi] <= evt_sel_t'(reg_wdata[SEL_W-1:0]);
            end
         end

         trk_ctr_slice #(
            .CTR_IDX (gi),
            .DEPTH   (DEPTH),
            .OCC_W   (OCC_W),
            .CNT_W   (CNT_W)
         ) u_slice (
            .clk           (clk),
            .rst_n         (rst_n),
            .sel           (sel_q[gi]),
            .trk_occ       (trk_occ),
            .coh_occ       (coh_occ),
            .alloc_vld     (alloc_vld),
            .alloc_kind    (alloc_kind),
            .coh_alloc_vld (coh_alloc_vld),
            .load_en       (reg_we && reg_addr == CNT_ADDR),
            .load_val      (reg_wdata),
            .cnt           (ctr_val[gi])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (reg_addr == ADDR_W'(i)) begin
            reg_rdata = CNT_W'(sel_q[i]);
         end
         if (reg_addr == ADDR_W'(NUM_CTR + i)) begin
            reg_rdata = ctr_val[i];
         end
      end
   end

endmodule

// File: rtl/trk_occ_mon_chk.sv
module trk_occ_mon_chk
   import trk_occ_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 48,
   parameter int OCC_W  = 5,
   parameter int ADDR_W = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          alloc_vld,
   input logic                          retire_vld,
   input logic [OCC_W-1:0]              trk_occ,
   input logic                          reg_we,
   input logic [ADDR_W-1:0]             reg_addr,
   input logic [CNT_W-1:0]              reg_wdata,
   input evt_sel_t [NUM_CTR-1:0]        sel_q,
   input logic [NUM_CTR-1:0][CNT_W-1:0] ctr_val
);

   logic load0, load1;
   assign load0 = reg_we && reg_addr == ADDR_W'(NUM_CTR);
   assign load1 = reg_we && reg_addr == ADDR_W'(NUM_CTR + 1);

   assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      trk_occ <= OCC_W'(DEPTH));

   assert_occ_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vld && retire_vld |=> trk_occ == $past(trk_occ));

   assert_no_weight_ctr1_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load1 && sel_q[1].code == EV_TRK_OCC && sel_q[1].mask == UM_ALL
      && sel_q[1].sub == 2'd0 |=> ctr_val[1] == $past(ctr_val[1]));

   assert_alloc_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load0 && alloc_vld && sel_q[0].code == EV_TRK_ALLOC && sel_q[0].mask == UM_ALL
      |=> ctr_val[0] == $past(ctr_val[0]) + CNT_W'(1));

   assert_unlisted_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load0 && sel_q[0].code == 8'h00 |=> ctr_val[0] == $past(ctr_val[0]));

   assert_ctr_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load0 |=> ctr_val[0] == $past(reg_wdata));

endmodule

bind trk_occ_mon trk_occ_mon_chk #(
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W),
   .OCC_W  (OCC_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .alloc_vld  (alloc_vld),
   .retire_vld (retire_vld),
   .trk_occ    (trk_occ),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .sel_q      (sel_q),
   .ctr_val    (ctr_val)
);

// File: tb/trk_occ_mon_test.sv
module trk_occ_mon_test;

   localparam int TD = 6;
   localparam int CW = 48;
   localparam int OW = $clog2(TD + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_vld = 1'b0;
   logic [1:0]    alloc_kind = 2'd0;
   logic          retire_vld = 1'b0;
   logic          coh_alloc_vld = 1'b0;
   logic          coh_retire_vld = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [CW-1:0] reg_wdata = '0;
   logic [CW-1:0] reg_rdata;
   logic [OW-1:0] trk_occ;

   trk_occ_mon #(.DEPTH(TD), .CNT_W(CW)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .alloc_vld      (alloc_vld),
      .alloc_kind     (alloc_kind),
      .retire_vld     (retire_vld),
      .coh_alloc_vld  (coh_alloc_vld),
      .coh_retire_vld (coh_retire_vld),
      .reg_we         (reg_we),
      .reg_addr       (reg_addr),
      .reg_wdata      (reg_wdata),
      .reg_rdata      (reg_rdata),
      .trk_occ        (trk_occ)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 0;

   logic [17:0]   m_sel [2];
   logic [CW-1:0] m_cnt [2];
   int            m_occ = 0;
   int            m_cocc = 0;
   logic [15:0]   lfsr = 16'hACE1;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic int exp_inc(int idx, logic [17:0] s, int occ, int cocc,
                                  bit a, bit [1:0] k, bit ca);
      logic [7:0] c = s[7:0];
      logic [7:0] m = s[15:8];
      logic [1:0] md = s[17:16];
      if (c == 8'h80 && m == 8'h01) begin
         case (md)
            2'd0: return (idx == 0) ? occ : 0;
            2'd1: return (occ != 0) ? 1 : 0;
            2'd2: return (2 * occ >= TD) ? 1 : 0;
            default: return 0;
         endcase
      end
      if (c == 8'h81) begin
         if (m == 8'h01) return a ? 1 : 0;
         if (m == 8'h20) return (a && k != 2'd0) ? 1 : 0;
         if (m == 8'h80) return (a && k == 2'd3) ? 1 : 0;
         return 0;
      end
      if (c == 8'h83 && m == 8'h01 && md == 2'd0) return (idx == 0) ? cocc : 0;
      if (c == 8'h84 && m == 8'h01) return ca ? 1 : 0;
      return 0;
   endfunction

   function automatic string tag_of(int idx, logic [17:0] s);
      logic [7:0] c = s[7:0];
      logic [7:0] m = s[15:8];
      logic [1:0] md = s[17:16];
      if (c == 8'h80 && m == 8'h01) begin
         if (md == 2'd0) return (idx == 0) ? "R2" : "R5";
         if (md == 2'd1) return "R3";
         if (md == 2'd2) return "R4";
         return "R5";
      end
      if (c == 8'h81 && m == 8'h01) return "R6";
      if (c == 8'h81 && (m == 8'h20 || m == 8'h80)) return "R7";
      if (c == 8'h83 || c == 8'h84) return "R8";
      return "R9";
   endfunction

   task automatic check(string tag, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // One clock: drive at negedge, check, advance the model, wait for the edge.
   task automatic step(bit a, bit [1:0] k, bit r, bit ca, bit cr,
                       bit we, bit [1:0] ad, logic [CW-1:0] wd,
                       bit rd_chk, string tag);
      int inc [2];
      @(negedge clk);
      alloc_vld = a; alloc_kind = k; retire_vld = r;
      coh_alloc_vld = ca; coh_retire_vld = cr;
      reg_we = we; reg_addr = ad; reg_wdata = wd;
      #1;
      check("R1", "occupancy", CW'(trk_occ), CW'(m_occ));
      if (rd_chk) begin
         if (ad < 2) check(tag, "selector", reg_rdata, CW'(m_sel[ad]));
         else        check(tag, "counter", reg_rdata, m_cnt[ad - 2]);
      end
      for (int i = 0; i < 2; i++)
         inc[i] = exp_inc(i, m_sel[i], m_occ, m_cocc, a, k, ca);
      for (int i = 0; i < 2; i++) begin
         if (we && ad == 2'(2 + i)) m_cnt[i] = wd;
         else                       m_cnt[i] = m_cnt[i] + CW'(inc[i]);
      end
      if (we && ad < 2) m_sel[ad] = wd[17:0];
      if (a && !r && m_occ < TD) m_occ++;
      else if (r && !a && m_occ > 0) m_occ--;
      if (ca && !cr && m_cocc < TD) m_cocc++;
      else if (cr && !ca && m_cocc > 0) m_cocc--;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, '0, 0, "");
   endtask

   task automatic wr(bit [1:0] ad, logic [CW-1:0] wd);
      step(0, 0, 0, 0, 0, 1, ad, wd, 0, "");
   endtask

   task automatic rd(bit [1:0] ad, string tag);
      step(0, 0, 0, 0, 0, 0, ad, '0, 1, tag);
   endtask

   logic [17:0] cfg [14];

   initial begin
      cfg[0]  = {2'd0, 8'h01, 8'h80};
      cfg[1]  = {2'd1, 8'h01, 8'h80};
      cfg[2]  = {2'd2, 8'h01, 8'h80};
      cfg[3]  = {2'd3, 8'h01, 8'h80};
      cfg[4]  = {2'd0, 8'h01, 8'h81};
      cfg[5]  = {2'd0, 8'h20, 8'h81};
      cfg[6]  = {2'd0, 8'h80, 8'h81};
      cfg[7]  = {2'd3, 8'h01, 8'h81};
      cfg[8]  = {2'd0, 8'h01, 8'h83};
      cfg[9]  = {2'd0, 8'h01, 8'h84};
      cfg[10] = {2'd0, 8'h02, 8'h81};
      cfg[11] = {2'd0, 8'h01, 8'h85};
      cfg[12] = {2'd1, 8'h01, 8'h83};
      cfg[13] = {2'd0, 8'h20, 8'h84};
      m_sel[0] = '0; m_sel[1] = '0; m_cnt[0] = '0; m_cnt[1] = '0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state of every register and the occupancy
      for (int a = 0; a < 4; a++) rd(2'(a), "R11");

      // R1: fill past DEPTH, simultaneous pulses, drain past zero
      for (int i = 0; i < TD + 3; i++) step(1, 2'd0, 0, 1, 0, 0, 0, '0, 0, "");
      step(1, 2'd3, 1, 1, 1, 0, 0, '0, 0, "");
      for (int i = 0; i < TD + 3; i++) step(0, 2'd0, 1, 0, 1, 0, 0, '0, 0, "");
      step(1, 2'd1, 1, 0, 0, 0, 0, '0, 0, "");

      // Sweep of every selector on both counters under mixed traffic
      for (int c = 0; c < 14; c++) begin
         wr(2'd0, CW'(cfg[c]));
         wr(2'd1, CW'(cfg[c]));
         wr(2'd2, '0);
         wr(2'd3, '0);
         for (int t = 0; t < 60; t++) begin
            bit fill;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fill = (t < 30);
            step(fill ? (lfsr[1:0] != 0) : (lfsr[1:0] == 0), lfsr[5:4],
                 fill ? (lfsr[3:2] == 0) : (lfsr[3:2] != 0),
                 fill ? (lfsr[6] | lfsr[9]) : (lfsr[6] & lfsr[9]),
                 fill ? (lfsr[7] & lfsr[8]) : (lfsr[7] | lfsr[8]),
                 0, 0, '0, 0, "");
         end
         rd(2'd2, tag_of(0, cfg[c]));
         rd(2'd3, tag_of(1, cfg[c]));
      end

      // R10: selector readback, write priority over increment, 48-bit wrap
      wr(2'd0, {30'h3FFF_FFFF, 18'h3_01_81});
      rd(2'd0, "R10");
      wr(2'd1, CW'(cfg[4]));
      step(1, 2'd2, 0, 0, 0, 1, 2'd3, CW'(77), 0, "");
      rd(2'd3, "R10");
      wr(2'd2, {CW{1'b1}} - CW'(2));
      for (int i = 0; i < 5; i++) step(1, 2'd0, 1, 0, 0, 0, 0, '0, 0, "");
      rd(2'd2, "R10");
      check("R10", "wrapped counter model", m_cnt[0], CW'(2));

      idle();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule